// File: doc/BRIEF.md
# Video Character Fetch and Pixel Serialiser

This block sits between a CPU, its display memory and a character ROM. It supports a video scheme where the CPU appears to run code out of display memory. When the CPU makes an opcode fetch from the upper half of the address space, the block keeps the real memory byte as a character code. It then makes the CPU see an all-zero opcode (NOP), so the program counter moves on to the next cell. On the refresh cycle that follows, the block builds a character-ROM address from the code and the low refresh-address bits, which act as the line counter. The ROM byte is then loaded into a shift register that sends out one pixel per clock.

All strobes are active low and are sampled on the rising clock edge. A small controller with four named states runs the sequence. `S_IDLE` waits for a video fetch and goes to `S_NOP` when it sees one, taking a copy of the memory byte on that edge. `S_NOP` forces zeros onto the CPU data and goes to `S_WAIT_RFSH` when it sees the memory request high outside refresh, latching the character code at that point. `S_WAIT_RFSH` goes to `S_ROM` on the first refresh memory cycle and registers the ROM address on that edge. `S_ROM` always returns to `S_IDLE`, pulsing the shift-register load on that edge.

Top module: `vfetch_top`

## Requirements
- R1: While reset is asserted, and after it is released, `char_code` is 0x00, `rom_addr` is 0 and `pix_out` is 0. With no video fetch in progress, `cpu_data` equals `mem_data`.
- R2: A video fetch is a cycle with `m1_n`=0, `mreq_n`=0, `a15`=1 and `rfsh_n`=1. `char_code` takes the byte that was on `mem_data` in the first cycle of the fetch. It is updated on the edge where `mreq_n` is first seen high again with `rfsh_n` high, and at no other time.
- R3: On the first cycle of a video fetch, `cpu_data` still equals `mem_data`. From the next cycle until `mreq_n` rises, `cpu_data` is 0x00 (NOP). Changes on `mem_data` during that time do not alter the captured code.
- R4: A fetch with `a15`=0 passes `mem_data` to `cpu_data` unchanged and leaves `char_code` unchanged.
- R5: On the first refresh memory cycle (`rfsh_n`=0, `mreq_n`=0) after a code is captured, `rom_addr` becomes {`char_code`[5:0], `rfsh_addr`[2:0]}, with the code in bits 8:3 and the line in bits 2:0. A refresh cycle with no pending capture leaves `rom_addr` unchanged.
- R6: One clock after `rom_addr` is updated, the shift register loads `rom_data`. `pix_out` then gives bits 7 down to 0 of the loaded value, one per clock. After that it is 0.
- R7: If bit 7 of the captured code is 1, the loaded pixel byte is the bitwise inverse of `rom_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| m1_n | input | 1 | CPU opcode-fetch cycle, active low |
| rfsh_n | input | 1 | CPU refresh cycle, active low |
| a15 | input | 1 | CPU address bit 15 |
| mem_data | input | 8 | Byte driven by display memory |
| rfsh_addr | input | 7 | Refresh address; the low bits select the glyph line |
| rom_data | input | 8 | Character ROM output for `rom_addr` |
| cpu_data | output | 8 | Data presented to the CPU |
| char_code | output | 8 | Latched character code |
| rom_addr | output | 9 | Character ROM address |
| pix_out | output | 1 | Serial pixel output |

## Verification
The bench uses the default parameters: an 8-bit data path, a 6-bit glyph index and 3 line bits. With these values every line of every glyph can be reached through a 512-entry ROM that the bench computes itself. Characters are sent with bit 7 both set and clear, and with a range of line numbers, so the bench covers inverted and plain cells and the extreme line values 0 and 7. It also covers fetches with the upper address bit low and refresh cycles that have no pending capture, and checks through the ports that neither one has any effect.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_NOP       = 2'd1,
        S_WAIT_RFSH = 2'd2,
        S_ROM       = 2'd3
    } vf_state_t;
endpackage

// File: rtl/vfetch_ctrl.sv
module vfetch_ctrl
    import vfetch_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CODE_BITS = 6,
    parameter int ROW_BITS  = 3,
    parameter int RA_W      = 7,
    localparam int AW       = CODE_BITS + ROW_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mreq_n,
    input  logic          m1_n,
    input  logic          rfsh_n,
    input  logic          a15,
    input  logic [DW-1:0] mem_data,
    input  logic [RA_W-1:0] rfsh_addr,
    output logic [DW-1:0] cpu_data,
    output logic [DW-1:0] char_code,
    output logic [AW-1:0] rom_addr,
    output logic          load_stb,
    output logic          invert
);
    vf_state_t state, state_nx;
    logic [DW-1:0] shadow;
    logic vid_fetch, rfsh_cyc, mreq_up;

    assign vid_fetch = !m1_n && !mreq_n && a15 && rfsh_n;
    assign rfsh_cyc  = !rfsh_n && !mreq_n;
    assign mreq_up   = mreq_n && rfsh_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (vid_fetch) state_nx = S_NOP;
            S_NOP:       if (mreq_up)   state_nx = S_WAIT_RFSH;
            S_WAIT_RFSH: if (rfsh_cyc)  state_nx = S_ROM;
            S_ROM:                      state_nx = S_IDLE;
            default:                    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow    <= '0;
            char_code <= '0;
            rom_addr  <= '0;
        end else begin
            if (state == S_IDLE && vid_fetch)
                shadow <= mem_data;
            if (state == S_NOP && mreq_up)
                char_code <= shadow;
            if (state == S_WAIT_RFSH && rfsh_cyc)
                rom_addr <= {char_code[CODE_BITS-1:0], rfsh_addr[ROW_BITS-1:0]};
        end
    end

    always_comb begin
        cpu_data = mem_data;
        load_stb = 1'b0;
        invert   = char_code[DW-1];
        unique case (state)
            S_NOP:   cpu_data = '0;
            S_ROM:   load_stb = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/vfetch_shifter.sv
module vfetch_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          invert,
    input  logic [DW-1:0] din,
    output logic          pix
);
    logic [DW-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sreg <= '0;
        else if (load) sreg <= din ^ {DW{invert}};
        else           sreg <= {sreg[DW-2:0], 1'b0};
    end

    assign pix = sreg[DW-1];
endmodule

// File: rtl/vfetch_top.sv
module vfetch_top #(
    parameter int DW        = 8,
    parameter int CODE_BITS = 6,
    parameter int ROW_BITS  = 3,
    parameter int RA_W      = 7,
    localparam int AW       = CODE_BITS + ROW_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mreq_n,
    input  logic          m1_n,
    input  logic          rfsh_n,
    input  logic          a15,
    input  logic [DW-1:0] mem_data,
    input  logic [RA_W-1:0] rfsh_addr,
    input  logic [DW-1:0] rom_data,
    output logic [DW-1:0] cpu_data,
    output logic [DW-1:0] char_code,
    output logic [AW-1:0] rom_addr,
    output logic          pix_out
);
    logic load_stb, invert;

    vfetch_ctrl #(
        .DW(DW), .CODE_BITS(CODE_BITS), .ROW_BITS(ROW_BITS), .RA_W(RA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n),
        .rfsh_n(rfsh_n), .a15(a15), .mem_data(mem_data),
        .rfsh_addr(rfsh_addr), .cpu_data(cpu_data), .char_code(char_code),
        .rom_addr(rom_addr), .load_stb(load_stb), .invert(invert)
    );

    vfetch_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_stb), .invert(invert),
        .din(rom_data), .pix(pix_out)
    );
endmodule

// File: rtl/vfetch_checker.sv
module vfetch_checker #(
    parameter int DW = 8,
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mreq_n,
    input logic          m1_n,
    input logic          rfsh_n,
    input logic          a15,
    input logic [DW-1:0] mem_data,
    input logic [DW-1:0] cpu_data,
    input logic [DW-1:0] char_code,
    input logic [AW-1:0] rom_addr,
    input logic          pix_out
);
    logic vid;
    assign vid = !m1_n && !mreq_n && a15 && rfsh_n;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (char_code == '0 && rom_addr == '0 && !pix_out));

    // R2
    code_on_mreq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(char_code) |-> ($past(mreq_n) && $past(rfsh_n) && !$past(mreq_n, 2)));

    // R3
    nop_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid && $past(vid)) |-> (cpu_data == '0));

    // R4
    low_fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n && !mreq_n && !a15 && rfsh_n) |-> (cpu_data == mem_data));

    // R5
    rom_addr_on_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rom_addr) |-> ($past(!rfsh_n) && $past(!mreq_n)));
endmodule

bind vfetch_top vfetch_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n),
    .rfsh_n(rfsh_n), .a15(a15), .mem_data(mem_data), .cpu_data(cpu_data),
    .char_code(char_code), .rom_addr(rom_addr), .pix_out(pix_out)
);

// File: tb/vfetch_top_test.sv
`timescale 1ns/1ps
module vfetch_top_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mreq_n = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1, a15 = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic [6:0] rfsh_addr = 7'h00;
    logic [7:0] rom_data;
    logic [7:0] cpu_data, char_code;
    logic [8:0] rom_addr;
    logic pix_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic exp_q[$];

    always #4 clk = ~clk;

    function automatic logic [7:0] rom_fn(input logic [8:0] a);
        logic [15:0] t;
        t = {7'd0, a} * 16'd37 + 16'd5;
        return t[7:0] ^ {a[8:6], 5'b0};
    endfunction

    assign rom_data = rom_fn(rom_addr);

    vfetch_top uut (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .m1_n(m1_n),
        .rfsh_n(rfsh_n), .a15(a15), .mem_data(mem_data),
        .rfsh_addr(rfsh_addr), .rom_data(rom_data), .cpu_data(cpu_data),
        .char_code(char_code), .rom_addr(rom_addr), .pix_out(pix_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected pixels (R6, R7)
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic e;
                e = exp_q.pop_front();
                check("R6/R7 pixel", {15'd0, pix_out}, {15'd0, e});
            end
        end
    end

    task automatic video_char(input logic [7:0] b, input logic [6:0] r);
        logic [7:0] pat;
        @(negedge clk);
        m1_n = 0; mreq_n = 0; a15 = 1; mem_data = b;
        #1 check("R3 first cycle passes", {8'd0, cpu_data}, {8'd0, b});
        @(negedge clk);
        check("R3 nop", {8'd0, cpu_data}, 16'd0);
        mem_data = ~b;
        @(negedge clk);
        check("R3 nop held", {8'd0, cpu_data}, 16'd0);
        mreq_n = 1; m1_n = 1; mem_data = 8'h00;
        @(negedge clk);
        check("R2 code", {8'd0, char_code}, {8'd0, b});
        a15 = 0; rfsh_n = 0; mreq_n = 0; rfsh_addr = r;
        @(negedge clk);
        check("R5 rom addr", {7'd0, rom_addr}, {7'd0, b[5:0], r[2:0]});
        rfsh_n = 1; mreq_n = 1;
        pat = rom_fn({b[5:0], r[2:0]}) ^ {8{b[7]}};
        @(posedge clk);
        #1;
        for (int i = 7; i >= 0; i--) exp_q.push_back(pat[i]);
        repeat (9) @(negedge clk);
        check("R6 background after cell", {15'd0, pix_out}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 code reset", {8'd0, char_code}, 16'd0);
        check("R1 pix reset", {15'd0, pix_out}, 16'd0);
        check("R1 addr reset", {7'd0, rom_addr}, 16'd0);
        mem_data = 8'h3C;
        #1 check("R1 idle pass", {8'd0, cpu_data}, 16'h003C);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {15'd0, pix_out}, 16'd0);

        video_char(8'h15, 7'h02);
        video_char(8'h8A, 7'h07);
        video_char(8'h7F, 7'h00);
        video_char(8'hC0, 7'h55);

        // R4: fetch with a15 low
        @(negedge clk);
        m1_n = 0; mreq_n = 0; a15 = 0; mem_data = 8'h5A;
        #1 check("R4 pass", {8'd0, cpu_data}, 16'h005A);
        @(negedge clk);
        check("R4 pass 2nd", {8'd0, cpu_data}, 16'h005A);
        m1_n = 1; mreq_n = 1;
        repeat (2) @(negedge clk);
        check("R4 code kept", {8'd0, char_code}, 16'h00C0);

        // R5: refresh with no pending capture
        rfsh_n = 0; mreq_n = 0; rfsh_addr = 7'h03;
        repeat (2) @(negedge clk);
        rfsh_n = 1; mreq_n = 1;
        @(negedge clk);
        check("R5 addr kept", {7'd0, rom_addr}, {7'd0, 6'h00, 3'd5});
        check("R6 no load", {15'd0, pix_out}, 16'd0);

        video_char(8'hFF, 7'h01);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule